// File: doc/BRIEF.md
# Rotating Unit-Element Selector for a Thermometer DAC

This block drives the enables of a DAC built from identical unit elements. Each cycle that a conversion result is presented, it turns on as many elements as the binary code asks for. It does not always start from the first element. It picks a contiguous run that begins right after the last element used by the previous conversion and wraps around the end of the array. Because every element is used equally often over time, the static mismatch between elements turns into an error whose spectrum is first-order high-pass, (1 − z⁻¹). That error falls mostly outside a low-frequency signal band.

The array holds 2^CODE_W elements. The code input is one bit wider than CODE_W, so that a request for every element can be expressed. A start pointer records where the next run begins. It is exposed as an observation output and is cleared by a synchronous, active-high reset. Enables and pointer are registered: a code presented with its valid flag at one rising edge shows up on the outputs right after that edge.

Top module: `dwa_selector`

## Requirements
- R1: While reset is high, and after it is released until the first valid code, `elem_en` is all zero and `ptr_dbg` is 0.
- R2: For a valid code c with 0 < c < 2^CODE_W, exactly c bits of `elem_en` are set after the edge that accepts it.
- R3: The set bits form a run that starts at the bit index given by the pointer value before the edge and rises in index, wrapping from bit 2^CODE_W−1 to bit 0. Bit i of `elem_en` enables element i.
- R4: After each valid code c, the pointer becomes (old pointer + c) modulo 2^CODE_W.
- R5: A valid code of 0 gives an all-zero `elem_en` and leaves the pointer unchanged.
- R6: A valid code equal to 2^CODE_W sets every bit of `elem_en` and leaves the pointer unchanged.
- R7: A valid code above 2^CODE_W is treated as 2^CODE_W.
- R8: A cycle with `in_valid` low gives an all-zero `elem_en` and holds the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Code on `in_code` is a conversion result this cycle |
| in_code | input | CODE_W+1 | Number of unit elements to turn on |
| elem_en | output | 2^CODE_W | Registered per-element enable, bit i for element i |
| ptr_dbg | output | CODE_W | Start position of the next run |

## Verification
The code 1 followed by 3 opens the run: it shows that the second run starts right after the first one, not at element 0. Runs of mid-size codes force the window across the top of the array. This separates a correct wrap from a window that is cut off or shifted by one. Zero, full-scale and over-range codes, mixed with idle cycles, show that the pointer holds exactly when it should. A long pseudo-random stream of codes and valid gaps, compared against a behavioural model on every cycle, catches pointer drift that accumulates over time.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

    typedef enum logic [1:0] {
        SEL_IDLE  = 2'd0,
        SEL_EMPTY = 2'd1,
        SEL_PART  = 2'd2,
        SEL_FULL  = 2'd3
    } sel_kind_e;

    localparam int DWA_CODE_W_DEFAULT = 3;

    function automatic int unsigned elem_count(input int unsigned code_w);
        return 32'd1 << code_w;
    endfunction

endpackage

// File: rtl/dwa_classify.sv
module dwa_classify
    import dwa_pkg::*;
#(
    parameter int CODE_W = DWA_CODE_W_DEFAULT
) (
    input  logic              valid,
    input  logic [CODE_W:0]   code,
    output sel_kind_e         kind,
    output logic [CODE_W:0]   count
);
    localparam int unsigned N_ELEM = elem_count(CODE_W);
    localparam logic [CODE_W:0] FULL_CNT = (CODE_W+1)'(N_ELEM);

    always_comb begin
        count = (code > FULL_CNT) ? FULL_CNT : code;
        if (!valid) begin
            kind  = SEL_IDLE;
            count = '0;
        end else if (code == '0) begin
            kind = SEL_EMPTY;
        end else if (count == FULL_CNT) begin
            kind = SEL_FULL;
        end else begin
            kind = SEL_PART;
        end
    end
endmodule

// File: rtl/dwa_window.sv
module dwa_window
    import dwa_pkg::*;
#(
    parameter int CODE_W = DWA_CODE_W_DEFAULT
) (
    input  logic [CODE_W-1:0]               start,
    input  logic [CODE_W:0]                 count,
    output logic [elem_count(CODE_W)-1:0]   mask
);
    localparam int unsigned N_ELEM = elem_count(CODE_W);

    for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
        logic [CODE_W-1:0] offset;
        assign offset  = CODE_W'(i) - start;
        assign mask[i] = ({1'b0, offset} < count);
    end
endmodule

// File: rtl/dwa_pointer.sv
module dwa_pointer
    import dwa_pkg::*;
#(
    parameter int CODE_W = DWA_CODE_W_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [CODE_W:0]   step,
    output logic [CODE_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= ptr + step[CODE_W-1:0];
        end
    end

    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(ptr))
        else $error("pointer moved without a valid code");
endmodule

// File: rtl/dwa_selector.sv
module dwa_selector
    import dwa_pkg::*;
#(
    parameter int CODE_W = DWA_CODE_W_DEFAULT,
    localparam int N_ELEM = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CODE_W:0]   in_code,
    output logic [N_ELEM-1:0] elem_en,
    output logic [CODE_W-1:0] ptr_dbg
);
    sel_kind_e          kind;
    logic [CODE_W:0]    count;
    logic [N_ELEM-1:0]  mask;
    logic [N_ELEM-1:0]  en_next;

    dwa_classify #(.CODE_W(CODE_W)) u_classify (
        .valid (in_valid),
        .code  (in_code),
        .kind  (kind),
        .count (count)
    );

    dwa_window #(.CODE_W(CODE_W)) u_window (
        .start (ptr_dbg),
        .count (count),
        .mask  (mask)
    );

    dwa_pointer #(.CODE_W(CODE_W)) u_pointer (
        .clk     (clk),
        .rst     (rst),
        .advance (in_valid),
        .step    (count),
        .ptr     (ptr_dbg)
    );

    always_comb begin
        unique case (kind)
            SEL_IDLE, SEL_EMPTY: en_next = '0;
            SEL_FULL:            en_next = '1;
            default:             en_next = mask;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            elem_en <= '0;
        end else begin
            elem_en <= en_next;
        end
    end

    p_count_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_code != '0 && in_code < (CODE_W+1)'(N_ELEM))
        |=> $countones(elem_en) == int'($past(in_code)))
        else $error("enabled count differs from code");

    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_code != '0) |=> elem_en[$past(ptr_dbg)])
        else $error("run does not begin at the pointer");

    p_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_code == '0) |=> (elem_en == '0 && $stable(ptr_dbg)))
        else $error("zero code changed state");

    p_full_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_code >= (CODE_W+1)'(N_ELEM)) |=> (&elem_en && $stable(ptr_dbg)))
        else $error("full or over-range code mishandled");

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> elem_en == '0)
        else $error("enables set in an idle cycle");
endmodule

// File: tb/dwa_selector_test.sv
module dwa_selector_test;
    localparam int CODE_W = 3;
    localparam int N = 1 << CODE_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [CODE_W:0]   in_code = '0;
    logic [N-1:0]      elem_en;
    logic [CODE_W-1:0] ptr_dbg;

    int checks = 0;
    int fails  = 0;
    int ref_ptr = 0;
    logic [N-1:0] exp_en = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dwa_selector #(.CODE_W(CODE_W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
        .elem_en(elem_en), .ptr_dbg(ptr_dbg)
    );

    task automatic compare(input string tag);
        checks++;
        if (elem_en !== exp_en || ptr_dbg !== CODE_W'(ref_ptr)) begin
            fails++;
            $display("FAIL %s: en=%b ptr=%0d expected en=%b ptr=%0d",
                     tag, elem_en, ptr_dbg, exp_en, ref_ptr);
        end
    endtask

    // inputs are applied at a falling edge; results sampled at the next one
    task automatic step(input bit v, input int code);
        string tag;
        int c;
        in_valid = v;
        in_code  = (CODE_W+1)'(code);
        @(posedge clk);
        exp_en = '0;
        if (!v) begin
            tag = "R8 idle";
        end else begin
            c = (code > N) ? N : code;
            for (int k = 0; k < c; k++) exp_en[(ref_ptr + k) % N] = 1'b1;
            ref_ptr = (ref_ptr + c) % N;
            if (code == 0)      tag = "R5 zero code";
            else if (code > N)  tag = "R7 over-range";
            else if (code == N) tag = "R6 full code";
            else                tag = "R2/R3/R4 partial run";
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        compare("R1 after reset");

        step(1, 1);          // element 0
        step(1, 3);          // elements 1..3, pointer 4
        step(1, 6);          // wraps: 4..7,0,1
        step(1, 0);
        step(0, 5);
        step(1, 8);
        step(1, 7);
        step(1, 15);
        step(1, 9);
        step(1, 2);
        for (int k = 0; k < 16; k++) step(1, 5);
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[7:6] != 2'b00, int'(lfsr[3:0]));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule